// File: doc/BRIEF.md
# Three-Channel PWM and Match Output Stage

This block is the pin-side output stage of a timer with three channels. A counter outside the block supplies a shared count value, and each channel has its own match value and match strobe. Each channel keeps a one-bit drive state. A two-bit action changes that bit when the channel's match strobe arrives: it can keep the bit, clear it, set it, or invert it. Software can also load the drive-state bits directly through a write port.

Each channel's pin can be driven in two ways. The first is a PWM comparator that compares the count against the match value. Its output mode selects one of two polarities, or forces the output low or high. The second is the channel's drive-state bit. A per-channel select chooses between these two sources. A separate per-channel pin-ownership bit decides whether the pin carries the timer output at all. When the timer does not own the pin, the pin follows a general-purpose data input, and the internal drive state keeps updating. Every pin output is registered.

Top module: `pwm_match_out`

## Requirements
- R1: While rstN is low, and on the first clock after reset, pinOut and emState are all zero.
- R2: At the clock edge where matchHit[i] is high, emState[i] takes the result of the action field emActCfg[2i+1:2i]. The encodings are 0 = keep, 1 = clear to 0, 2 = set to 1 and 3 = invert.
- R3: When matchHit[i] is high with a non-zero action, the action wins over a software write in the same cycle. When the action is 0 (keep), a software write in that cycle still loads the bit.
- R4: With no active match action, a clock edge with emWrEn high loads emState[i] from emWrData[i]. With emWrEn low and no action, emState holds.
- R5: With pinOwn[i]=1, pwmSel[i]=1 and outMode[2i+1:2i]=0, pinOut[i] is 0 when count is below the channel's match value and 1 otherwise. The output appears one clock after that count.
- R6: With outMode field 1, the PWM output is the exact inverse of R5, with the same one-clock latency.
- R7: With outMode field 2, pinOut[i] is 0 and with field 3 it is 1, one clock later, whatever the count.
- R8: With pinOwn[i]=1 and pwmSel[i]=0, pinOut[i] equals emState[i] as it stood one clock earlier, and outMode has no effect.
- R9: With pinOwn[i]=0, pinOut[i] equals gpioData[i] one clock later, while emState[i] keeps updating from match actions.
- R10: The channel fields are independent. The match value for channel i sits at matchVal[16i+15:16i], and each channel's configuration affects only that channel's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| count | input | CNT_W | Shared count value from the counter |
| matchVal | input | NUM_CH*CNT_W | Per-channel match values, channel i at slice i |
| matchHit | input | NUM_CH | Per-channel match strobes |
| emActCfg | input | 2*NUM_CH | Per-channel match action (keep/clear/set/invert) |
| emWrEn | input | 1 | Software write strobe for the drive-state bits |
| emWrData | input | NUM_CH | Value loaded by a software write |
| pwmSel | input | NUM_CH | 1 = PWM comparator drives pin, 0 = drive-state bit |
| outMode | input | 2*NUM_CH | Per-channel PWM mode (polarity A, polarity B, force 0, force 1) |
| pinOwn | input | NUM_CH | 1 = pin carries timer output, 0 = general-purpose data |
| gpioData | input | NUM_CH | General-purpose pin data |
| pinOut | output | NUM_CH | Registered pin outputs |
| emState | output | NUM_CH | Current drive-state bits |

## Verification
Two functions can hit the same drive-state bit on the same edge: the match action and the software write. The bench raises a match strobe and emWrEn together, with write data opposite to the action's result, and expects the action's value. It also pairs a keep action with a write and expects the written value. A third case toggles the drive state while pin ownership is released. The pin must track the general-purpose data, and the later read of emState must show that the toggle still took place.

// File: rtl/pwm_match_pkg.sv
package pwm_match_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } emAction_e;

  typedef enum logic [1:0] {
    MODE_PWM_A    = 2'd0,
    MODE_PWM_B    = 2'd1,
    MODE_FORCE_LO = 2'd2,
    MODE_FORCE_HI = 2'd3
  } outMode_e;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic drvLo;
    logic drvHi;
    logic flip;
    logic swLoad;
    logic useGpio;
    logic usePwm;
    logic pwmInvert;
    logic forceLo;
    logic forceHi;
  } chStrobe_t;

endpackage

// File: rtl/pwm_match_ctrl.sv
module pwm_match_ctrl
  import pwm_match_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0]   matchHit,
  input  logic [2*NUM_CH-1:0] emActCfg,
  input  logic                emWrEn,
  input  logic [NUM_CH-1:0]   pwmSel,
  input  logic [2*NUM_CH-1:0] outMode,
  input  logic [NUM_CH-1:0]   pinOwn,
  output chStrobe_t [NUM_CH-1:0] strobes
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    emAction_e act;
    outMode_e  mode;
    logic      hwAct;

    assign act   = emAction_e'(emActCfg[2*i +: 2]);
    assign mode  = outMode_e'(outMode[2*i +: 2]);
    assign hwAct = matchHit[i] && (act != ACT_KEEP);

    assign strobes[i].drvLo     = matchHit[i] && (act == ACT_LOW);
    assign strobes[i].drvHi     = matchHit[i] && (act == ACT_HIGH);
    assign strobes[i].flip      = matchHit[i] && (act == ACT_FLIP);
    assign strobes[i].swLoad    = emWrEn && !hwAct;
    assign strobes[i].useGpio   = !pinOwn[i];
    assign strobes[i].usePwm    = pwmSel[i];
    assign strobes[i].pwmInvert = (mode == MODE_PWM_B);
    assign strobes[i].forceLo   = (mode == MODE_FORCE_LO);
    assign strobes[i].forceHi   = (mode == MODE_FORCE_HI);
  end

endmodule

// File: rtl/pwm_match_dp.sv
module pwm_match_dp
  import pwm_match_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [CNT_W-1:0]          count,
  input  logic [NUM_CH*CNT_W-1:0]   matchVal,
  input  logic [NUM_CH-1:0]         emWrData,
  input  logic [NUM_CH-1:0]         gpioData,
  input  chStrobe_t [NUM_CH-1:0]    strobes,
  output logic [NUM_CH-1:0]         emState,
  output logic [NUM_CH-1:0]         pinOut
);

  logic [NUM_CH-1:0] emNext;
  logic [NUM_CH-1:0] pinNext;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    chStrobe_t s;
    logic      below;
    logic      pwmLvl;

    assign s     = strobes[i];
    assign below = count < matchVal[i*CNT_W +: CNT_W];

    always_comb begin
      if (s.forceLo)        pwmLvl = 1'b0;
      else if (s.forceHi)   pwmLvl = 1'b1;
      else if (s.pwmInvert) pwmLvl = below;
      else                  pwmLvl = !below;
    end

    always_comb begin
      if (s.drvLo)       emNext[i] = 1'b0;
      else if (s.drvHi)  emNext[i] = 1'b1;
      else if (s.flip)   emNext[i] = !emState[i];
      else if (s.swLoad) emNext[i] = emWrData[i];
      else               emNext[i] = emState[i];
    end

    always_comb begin
      if (s.useGpio)     pinNext[i] = gpioData[i];
      else if (s.usePwm) pinNext[i] = pwmLvl;
      else               pinNext[i] = emState[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emState <= '0;
      pinOut  <= '0;
    end else begin
      emState <= emNext;
      pinOut  <= pinNext;
    end
  end

endmodule

// File: rtl/pwm_match_out.sv
module pwm_match_out
  import pwm_match_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CNT_W-1:0]        count,
  input  logic [NUM_CH*CNT_W-1:0] matchVal,
  input  logic [NUM_CH-1:0]       matchHit,
  input  logic [2*NUM_CH-1:0]     emActCfg,
  input  logic                    emWrEn,
  input  logic [NUM_CH-1:0]       emWrData,
  input  logic [NUM_CH-1:0]       pwmSel,
  input  logic [2*NUM_CH-1:0]     outMode,
  input  logic [NUM_CH-1:0]       pinOwn,
  input  logic [NUM_CH-1:0]       gpioData,
  output logic [NUM_CH-1:0]       pinOut,
  output logic [NUM_CH-1:0]       emState
);

  chStrobe_t [NUM_CH-1:0] strobes;

  pwm_match_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .matchHit (matchHit),
    .emActCfg (emActCfg),
    .emWrEn   (emWrEn),
    .pwmSel   (pwmSel),
    .outMode  (outMode),
    .pinOwn   (pinOwn),
    .strobes  (strobes)
  );

  pwm_match_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .count    (count),
    .matchVal (matchVal),
    .emWrData (emWrData),
    .gpioData (gpioData),
    .strobes  (strobes),
    .emState  (emState),
    .pinOut   (pinOut)
  );

endmodule

// File: rtl/pwm_match_chk.sv
module pwm_match_chk #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [CNT_W-1:0]        count,
  input logic [NUM_CH*CNT_W-1:0] matchVal,
  input logic [NUM_CH-1:0]       matchHit,
  input logic [2*NUM_CH-1:0]     emActCfg,
  input logic                    emWrEn,
  input logic [NUM_CH-1:0]       emWrData,
  input logic [NUM_CH-1:0]       pwmSel,
  input logic [2*NUM_CH-1:0]     outMode,
  input logic [NUM_CH-1:0]       pinOwn,
  input logic [NUM_CH-1:0]       gpioData,
  input logic [NUM_CH-1:0]       pinOut,
  input logic [NUM_CH-1:0]       emState
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_ACT_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (matchHit[i] && emActCfg[2*i +: 2] == 2'd1) |=> !emState[i]);  // R2
    AST_ACT_HIGH_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (matchHit[i] && emActCfg[2*i +: 2] == 2'd2) |=> emState[i]);  // R3
    AST_ACT_FLIP: assert property (@(posedge clk) disable iff (!rstN)
      (matchHit[i] && emActCfg[2*i +: 2] == 2'd3) |=> emState[i] != $past(emState[i]));  // R2
    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      ((!matchHit[i] || emActCfg[2*i +: 2] == 2'd0) && emWrEn) |=> emState[i] == $past(emWrData[i]));  // R4
    AST_EM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      ((!matchHit[i] || emActCfg[2*i +: 2] == 2'd0) && !emWrEn) |=> $stable(emState[i]));  // R4
    AST_PWM_A: assert property (@(posedge clk) disable iff (!rstN)
      (pinOwn[i] && pwmSel[i] && outMode[2*i +: 2] == 2'd0)
        |=> pinOut[i] == ($past(count) >= $past(matchVal[i*CNT_W +: CNT_W])));  // R5
    AST_PWM_B: assert property (@(posedge clk) disable iff (!rstN)
      (pinOwn[i] && pwmSel[i] && outMode[2*i +: 2] == 2'd1)
        |=> pinOut[i] == ($past(count) < $past(matchVal[i*CNT_W +: CNT_W])));  // R6
    AST_FORCE_HI: assert property (@(posedge clk) disable iff (!rstN)
      (pinOwn[i] && pwmSel[i] && outMode[2*i +: 2] == 2'd3) |=> pinOut[i]);  // R7
    AST_FORCE_LO: assert property (@(posedge clk) disable iff (!rstN)
      (pinOwn[i] && pwmSel[i] && outMode[2*i +: 2] == 2'd2) |=> !pinOut[i]);  // R7
    AST_EM_PIN: assert property (@(posedge clk) disable iff (!rstN)
      (pinOwn[i] && !pwmSel[i]) |=> pinOut[i] == $past(emState[i]));  // R8
    AST_GPIO_PIN: assert property (@(posedge clk) disable iff (!rstN)
      !pinOwn[i] |=> pinOut[i] == $past(gpioData[i]));  // R9
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (pinOut == '0 && emState == '0));  // R1

endmodule

bind pwm_match_out pwm_match_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .count(count), .matchVal(matchVal),
  .matchHit(matchHit), .emActCfg(emActCfg), .emWrEn(emWrEn),
  .emWrData(emWrData), .pwmSel(pwmSel), .outMode(outMode),
  .pinOwn(pinOwn), .gpioData(gpioData), .pinOut(pinOut), .emState(emState)
);

// File: tb/pwm_match_out_tb.sv
module pwm_match_out_tb;
  localparam int NUM_CH = 3;
  localparam int CNT_W  = 16;

  logic                    clk = 1'b0;
  logic                    rstN;
  logic [CNT_W-1:0]        count;
  logic [NUM_CH*CNT_W-1:0] matchVal;
  logic [NUM_CH-1:0]       matchHit;
  logic [2*NUM_CH-1:0]     emActCfg;
  logic                    emWrEn;
  logic [NUM_CH-1:0]       emWrData;
  logic [NUM_CH-1:0]       pwmSel;
  logic [2*NUM_CH-1:0]     outMode;
  logic [NUM_CH-1:0]       pinOwn;
  logic [NUM_CH-1:0]       gpioData;
  logic [NUM_CH-1:0]       pinOut;
  logic [NUM_CH-1:0]       emState;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  pwm_match_out #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .count(count), .matchVal(matchVal),
    .matchHit(matchHit), .emActCfg(emActCfg), .emWrEn(emWrEn),
    .emWrData(emWrData), .pwmSel(pwmSel), .outMode(outMode),
    .pinOwn(pinOwn), .gpioData(gpioData), .pinOut(pinOut), .emState(emState)
  );

  // {count, expected pinOut[2:0]}; ch0 mode A match 10, ch1 mode B match 10, ch2 mode A match 0
  localparam logic [18:0] PWM_VEC [7] = '{
    {16'd0,     3'b110},
    {16'd9,     3'b110},
    {16'd10,    3'b101},
    {16'd11,    3'b101},
    {16'd3,     3'b110},
    {16'hFFFF,  3'b101},
    {16'd10,    3'b101}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; count = '0; matchVal = '0; matchHit = '0; emActCfg = '0;
    emWrEn = 1'b0; emWrData = '0; pwmSel = '0; outMode = '0; pinOwn = '0;
    gpioData = 3'b111;
    tick(); tick();
    // R1: reset state
    check("R1 pinOut", 8'(pinOut), 8'h0);
    check("R1 emState", 8'(emState), 8'h0);
    rstN = 1'b1;
    pinOwn = 3'b111;

    // R5 R6 R10: PWM vector walk
    pwmSel   = 3'b111;
    outMode  = {2'd0, 2'd1, 2'd0};
    matchVal = {16'd0, 16'd10, 16'd10};
    for (int k = 0; k < 7; k++) begin
      count = PWM_VEC[k][18:3];
      tick();
      check($sformatf("R5 R6 R10 pwm vec %0d", k), 8'(pinOut), 8'(PWM_VEC[k][2:0]));
    end

    // R7: forced levels regardless of count
    outMode = {2'd3, 2'd2, 2'd3};
    count = 16'd0;
    tick();
    check("R7 force cnt0", 8'(pinOut), 8'b101);
    count = 16'd50;
    tick();
    check("R7 force cnt50", 8'(pinOut), 8'b101);

    // R2: match actions; pins driven from drive state (R8)
    pwmSel = 3'b000;
    outMode = {2'd3, 2'd3, 2'd3};   // ignored in this path (R8)
    matchHit = 3'b001; emActCfg = {2'd0, 2'd0, 2'd2};
    tick();
    matchHit = '0;
    check("R2 set high ch0", 8'(emState), 8'b001);
    tick();
    check("R8 pin follows state", 8'(pinOut), 8'b001);

    matchHit = 3'b011; emActCfg = {2'd0, 2'd3, 2'd3};
    tick();
    matchHit = '0;
    check("R2 toggle ch0 ch1", 8'(emState), 8'b010);
    matchHit = 3'b111; emActCfg = {2'd0, 2'd1, 2'd0};
    tick();
    matchHit = '0;
    check("R2 keep and clear", 8'(emState), 8'b000);
    tick();
    check("R8 force mode ignored", 8'(pinOut), 8'b000);

    // R3: hardware action beats software write
    matchHit = 3'b010; emActCfg = {2'd0, 2'd2, 2'd0};
    emWrEn = 1'b1; emWrData = 3'b001;
    tick();
    check("R3 action wins", 8'(emState), 8'b011);
    matchHit = 3'b111; emActCfg = {2'd0, 2'd0, 2'd0};
    emWrData = 3'b100;
    tick();
    check("R3 keep lets write in", 8'(emState), 8'b100);
    matchHit = '0;

    // R4: software write and hold
    emWrData = 3'b101;
    tick();
    emWrEn = 1'b0; emWrData = 3'b010;
    check("R4 sw load", 8'(emState), 8'b101);
    tick();
    check("R4 hold", 8'(emState), 8'b101);

    // R9: gpio fallback while state keeps updating
    pinOwn = 3'b000; gpioData = 3'b110;
    matchHit = 3'b111; emActCfg = {2'd3, 2'd3, 2'd3};
    tick();
    matchHit = '0;
    check("R9 pin is gpio", 8'(pinOut), 8'b110);
    check("R9 state still toggles", 8'(emState), 8'b010);
    gpioData = 3'b001;
    tick();
    check("R9 pin tracks gpio", 8'(pinOut), 8'b001);

    // R10: mixed ownership and sources per channel
    pinOwn = 3'b011; pwmSel = 3'b001; outMode = {2'd2, 2'd2, 2'd3};
    gpioData = 3'b100;
    tick();
    check("R10 mixed channels", 8'(pinOut), 8'b111);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule